// File: doc/BRIEF.md
# Jump and Link Control Unit

This block produces the program counter update and the link value for a 32-bit RISC-V style integer core. It holds the program counter in its own register. For each instruction presented with a valid strobe, it decides the next address and loads the register on the following clock edge.

The block recognises three cases. The first is a PC-relative jump with a 20-bit scrambled immediate. The second is a register-indirect jump with a 12-bit immediate. Every other opcode falls into the third case and advances sequentially. Both jumps expose the return address (current PC plus 4) as link data, together with the destination register index and a write enable. The write enable stays low when the destination is register zero.

An indirect-jump encoding with a nonzero sub-function field is flagged as illegal. It then leaves the PC and the register file untouched. Conditional branches, arithmetic, memory access and trap vectoring belong to other blocks.

Top module: `jlink_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads `pc_o` with the parameter `RESET_VEC`. While `rst` is high, no register write is requested.
- R2: While `valid_i` is low, `pc_o` holds its value, `next_pc_o` equals `pc_o`, and `rd_we_o` and `illegal_o` stay low.
- R3: A valid instruction whose opcode (bits 6:0) is neither 1101111 nor 1100111 sets `next_pc_o` to `pc_o` + 4. `pc_o` takes that value on the next edge, and `rd_we_o` stays low.
- R4: Opcode 1101111 (direct jump) targets `pc_o` plus a sign-extended offset. The offset bits are {inst[31], inst[19:12], inst[20], inst[30:21], 0}, which is bit 20 down to bit 0.
- R5: For either jump, `link_data_o` is `pc_o` + 4 and `rd_idx_o` is inst[11:7]. `rd_we_o` is high when that index is nonzero.
- R6: A jump whose destination index is 0 still loads the target, but `rd_we_o` stays low.
- R7: Opcode 1100111 with inst[14:12] = 000 (indirect jump) targets `rs1_data_i` plus the sign-extended inst[31:20], with bit 0 of the sum forced to 0.
- R8: Opcode 1100111 with inst[14:12] other than 000 raises `illegal_o`, keeps `next_pc_o` equal to `pc_o`, leaves `pc_o` unchanged and keeps `rd_we_o` low.
- R9: All address additions wrap modulo 2^32.
- R10: An indirect jump whose destination index equals its source index computes its target from the `rs1_data_i` value presented with that instruction, not from the link value.
- R11: A taken jump loads exactly the target on the next edge, with no extra +4 applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction on `instr_i` is to be executed this cycle |
| instr_i | input | 32 | Instruction word |
| rs1_data_i | input | 32 | Value read from the source register |
| pc_o | output | 32 | Current program counter (registered) |
| next_pc_o | output | 32 | Address the PC will take on the next edge |
| link_data_o | output | 32 | Return address, `pc_o` + 4 |
| rd_idx_o | output | 5 | Destination register index |
| rd_we_o | output | 1 | Register write request for the link value |
| illegal_o | output | 1 | Illegal indirect-jump encoding |

## Verification
The stimulus covers four kinds of input:

- **Direct jumps.** Forward, backward and extreme offsets (largest positive and most negative) show whether each scrambled immediate field lands in the right bit position and whether the sign extension is correct.
- **Indirect jumps.** Odd sums show the forced clearing of bit 0. Negative immediates and a wrapping source value show modulo arithmetic. A case with the same source and destination index shows that the presented source value is used.
- **Non-jump opcodes and idle cycles.** These separate sequential advance from holding.
- **Bad sub-function codes.** These show that an illegal encoding neither moves the PC nor requests a write.

A behavioural model follows the PC across all of these and compares every output on every cycle.

// File: rtl/jlink_pkg.sv
package jlink_pkg;
   localparam int INSN_W = 32;
   localparam int REG_W  = 5;
   localparam logic [6:0] OPC_DJUMP = 7'b1101111;
   localparam logic [6:0] OPC_IJUMP = 7'b1100111;

   typedef enum logic [1:0] {
      FLOW_SEQ   = 2'd0,
      FLOW_DJUMP = 2'd1,
      FLOW_IJUMP = 2'd2,
      FLOW_BAD   = 2'd3
   } flow_e;
endpackage

// File: rtl/jlink_decode.sv
module jlink_decode
   import jlink_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [INSN_W-1:0] instr,
   output flow_e             flow,
   output logic [REG_W-1:0]  rd,
   output logic [XLEN-1:0]   imm_dj,
   output logic [XLEN-1:0]   imm_ij
);
   logic [2:0] subfn;

   assign subfn = instr[14:12];
   assign rd    = instr[11:7];

   // scrambled 21-bit offset, reassembled high to low
   assign imm_dj = {{(XLEN-21){instr[31]}}, instr[31], instr[19:12],
                    instr[20], instr[30:21], 1'b0};
   assign imm_ij = {{(XLEN-12){instr[31]}}, instr[31:20]};

   always_comb begin
      unique case (instr[6:0])
         OPC_DJUMP: flow = FLOW_DJUMP;
         OPC_IJUMP: flow = (subfn == 3'b000) ? FLOW_IJUMP : FLOW_BAD;
         default:   flow = FLOW_SEQ;
      endcase
   end
endmodule

// File: rtl/jlink_target.sv
module jlink_target
   import jlink_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter bit SHARE_ADDER = 1'b1
) (
   input  flow_e           flow,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] imm_dj,
   input  logic [XLEN-1:0] imm_ij,
   output logic [XLEN-1:0] jump_tgt,
   output logic [XLEN-1:0] seq_pc
);
   localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

   logic indirect;
   assign indirect = (flow == FLOW_IJUMP);
   assign seq_pc   = pc + PC_STEP;

   generate
      if (SHARE_ADDER) begin : g_shared
         logic [XLEN-1:0] base, offs, sum;
         assign base     = indirect ? rs1_val : pc;
         assign offs     = indirect ? imm_ij  : imm_dj;
         assign sum      = base + offs;
         assign jump_tgt = {sum[XLEN-1:1], sum[0] & ~indirect};
      end else begin : g_split
         logic [XLEN-1:0] sum_dj, sum_ij;
         assign sum_dj   = pc + imm_dj;
         assign sum_ij   = rs1_val + imm_ij;
         assign jump_tgt = indirect ? {sum_ij[XLEN-1:1], 1'b0} : sum_dj;
      end
   endgenerate
endmodule

// File: rtl/jlink_pcreg.sv
module jlink_pcreg #(
   parameter int              XLEN      = 32,
   parameter logic [XLEN-1:0] RESET_VEC = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic [XLEN-1:0] d,
   output logic [XLEN-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= RESET_VEC;
      else if (load) q <= d;
   end
endmodule

// File: rtl/jlink_ctrl.sv
module jlink_ctrl
   import jlink_pkg::*;
#(
   parameter int          XLEN        = 32,
   parameter logic [31:0] RESET_VEC   = 32'h0000_0000,
   parameter bit          SHARE_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [31:0]       instr_i,
   input  logic [31:0]       rs1_data_i,
   output logic [31:0]       pc_o,
   output logic [31:0]       next_pc_o,
   output logic [31:0]       link_data_o,
   output logic [4:0]        rd_idx_o,
   output logic              rd_we_o,
   output logic              illegal_o
);
   localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("jlink_ctrl: XLEN must be 32");
      end
      if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
         $error("jlink_ctrl: RESET_VEC must be word aligned");
      end
   endgenerate

   flow_e            flow;
   logic [REG_W-1:0] rd;
   logic [XLEN-1:0]  imm_dj, imm_ij, jump_tgt, seq_pc, pc_q;
   logic             is_jump, load;

   jlink_decode #(.XLEN(XLEN)) u_dec (
      .instr(instr_i), .flow(flow), .rd(rd),
      .imm_dj(imm_dj), .imm_ij(imm_ij)
   );

   jlink_target #(.XLEN(XLEN), .SHARE_ADDER(SHARE_ADDER)) u_tgt (
      .flow(flow), .pc(pc_q), .rs1_val(rs1_data_i),
      .imm_dj(imm_dj), .imm_ij(imm_ij),
      .jump_tgt(jump_tgt), .seq_pc(seq_pc)
   );

   assign is_jump = (flow == FLOW_DJUMP) || (flow == FLOW_IJUMP);

   always_comb begin
      next_pc_o = pc_q;
      if (valid_i) begin
         unique case (flow)
            FLOW_SEQ:               next_pc_o = seq_pc;
            FLOW_DJUMP, FLOW_IJUMP: next_pc_o = jump_tgt;
            default:                next_pc_o = pc_q;
         endcase
      end
   end

   assign load        = valid_i && (flow != FLOW_BAD);
   assign link_data_o = seq_pc;
   assign rd_idx_o    = rd;
   assign rd_we_o     = valid_i && !rst && is_jump && (rd != '0);
   assign illegal_o   = valid_i && (flow == FLOW_BAD);
   assign pc_o        = pc_q;

   jlink_pcreg #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_pc (
      .clk(clk), .rst(rst), .load(load), .d(next_pc_o), .q(pc_q)
   );

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(pc_o));
   // R3
   seq_step_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_i && flow == FLOW_SEQ) |=> (pc_o == $past(pc_o) + PC_STEP));
   // R6
   x0_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
      rd_we_o |-> (rd_idx_o != '0));
   // R7
   ijump_even_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_i && flow == FLOW_IJUMP) |-> !next_pc_o[0]);
   // R8
   bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      illegal_o |-> (!rd_we_o && next_pc_o == pc_o));
   // R8
   bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
      illegal_o |=> $stable(pc_o));
   // R11
   jump_load_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_i && is_jump) |=> (pc_o == $past(next_pc_o)));
endmodule

// File: tb/jlink_ctrl_test.sv
module jlink_ctrl_test;
   localparam logic [31:0] RVEC = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_i = 1'b0;
   logic [31:0] instr_i = 32'h0000_0013;
   logic [31:0] rs1_data_i = '0;
   logic [31:0] pc_o, next_pc_o, link_data_o;
   logic [4:0]  rd_idx_o;
   logic        rd_we_o, illegal_o;

   int compared = 0;
   int mismatched = 0;
   logic [31:0] m_pc;

   always #2 clk = ~clk;

   jlink_ctrl #(.RESET_VEC(RVEC)) uut (
      .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
      .rs1_data_i(rs1_data_i), .pc_o(pc_o), .next_pc_o(next_pc_o),
      .link_data_o(link_data_o), .rd_idx_o(rd_idx_o), .rd_we_o(rd_we_o),
      .illegal_o(illegal_o)
   );

   function automatic logic [31:0] enc_dj(input logic [4:0] rd, input int off);
      logic [20:0] o;
      o = off[20:0];
      return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
   endfunction

   function automatic logic [31:0] enc_ij(input logic [4:0] rd, input logic [4:0] rs,
                                          input logic [2:0] f3, input int imm);
      logic [11:0] i;
      i = imm[11:0];
      return {i, rs, f3, rd, 7'b1100111};
   endfunction

   task automatic cmp(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one instruction cycle: drive at negedge, compare, then let the edge pass
   task automatic step(input string req, input logic v, input logic [31:0] ins,
                       input logic [31:0] rs1v);
      logic [31:0] e_next;
      logic        e_we, e_ill;
      int          offs;
      @(negedge clk);
      valid_i = v; instr_i = ins; rs1_data_i = rs1v;
      #1;
      e_we = 1'b0; e_ill = 1'b0; e_next = m_pc;
      if (v) begin
         if (ins[6:0] == 7'b1101111) begin
            offs = $signed({ins[31], ins[19:12], ins[20], ins[30:21], 1'b0});
            e_next = m_pc + offs;
            e_we = (ins[11:7] != 0);
         end else if (ins[6:0] == 7'b1100111) begin
            if (ins[14:12] != 3'b000) e_ill = 1'b1;
            else begin
               offs = $signed(ins[31:20]);
               e_next = (rs1v + offs) & 32'hFFFF_FFFE;
               e_we = (ins[11:7] != 0);
            end
         end else e_next = m_pc + 4;
      end
      cmp(req, "pc", pc_o, m_pc);
      cmp(req, "next_pc", next_pc_o, e_next);
      cmp(req, "we", {31'b0, rd_we_o}, {31'b0, e_we});
      cmp(req, "illegal", {31'b0, illegal_o}, {31'b0, e_ill});
      if (e_we) begin
         cmp(req, "link", link_data_o, m_pc + 4);
         cmp(req, "rd", {27'b0, rd_idx_o}, {27'b0, ins[11:7]});
      end
      @(posedge clk);
      m_pc = e_next;
   endtask

   initial begin
      #(4 * 200000);
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset value and no write during reset
      valid_i = 1'b1; instr_i = enc_dj(5'd1, 8);
      #1;
      cmp("R1", "we_in_reset", {31'b0, rd_we_o}, 32'd0);
      @(negedge clk);
      rst = 1'b0; valid_i = 1'b0;
      cmp("R1", "pc_reset", pc_o, RVEC);
      m_pc = RVEC;

      step("R2", 1'b0, enc_dj(5'd1, 64), 32'h0);
      step("R2", 1'b0, enc_ij(5'd1, 5'd2, 3'b000, 4), 32'h40);
      step("R3", 1'b1, 32'h0000_0013, 32'h0);
      step("R3", 1'b1, 32'h00A0_0093, 32'h0);
      step("R3", 1'b1, 32'h0011_2023, 32'h0);
      step("R4", 1'b1, enc_dj(5'd1, 8), 32'h0);
      step("R11", 1'b1, enc_dj(5'd5, -12), 32'h0);
      step("R5", 1'b1, enc_dj(5'd31, 2048), 32'h0);
      step("R4", 1'b1, enc_dj(5'd1, 32'h000F_FFFE), 32'h0);
      step("R4", 1'b1, enc_dj(5'd1, -1048576), 32'h0);
      step("R6", 1'b1, enc_dj(5'd0, 20), 32'h0);
      step("R7", 1'b1, enc_ij(5'd1, 5'd2, 3'b000, 3), 32'h0000_2000);
      step("R7", 1'b1, enc_ij(5'd3, 5'd4, 3'b000, -7), 32'h0000_3000);
      step("R6", 1'b1, enc_ij(5'd0, 5'd1, 3'b000, 0), 32'h0000_0010);
      step("R9", 1'b1, enc_dj(5'd1, -32), 32'h0);
      step("R9", 1'b1, enc_ij(5'd2, 5'd6, 3'b000, 32), 32'hFFFF_FFF0);
      step("R10", 1'b1, enc_ij(5'd5, 5'd5, 3'b000, 16), 32'h0000_5001);
      for (int f = 1; f < 8; f++)
         step("R8", 1'b1, enc_ij(5'd1, 5'd2, 3'(f), 8), 32'h0000_7000);
      step("R3", 1'b1, 32'h0000_0033, 32'h0);
      step("R2", 1'b0, 32'h0000_0013, 32'h0);
      @(negedge clk);
      cmp("R2", "pc_final", pc_o, m_pc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule